// File: doc/BRIEF.md
# Audio Codec DMA Request Controller

This block generates the per-sample DMA request handshakes between a stereo audio codec and an 8-bit host bus. It has a playback path and a capture path. Each path raises a request once per sample period, at a phase marker supplied by the codec's sample timing. The request then stays high until the host acknowledges it and has moved every byte of one sample.

In two-channel mode each path uses its own request and acknowledge pair. In single-channel mode both paths share the playback pair. In that mode the enable bits decide which direction is in use, and playback wins when both are set.

A transfer counter is loaded from a base value and counts completed samples. When it underflows it raises a sticky interrupt. A per-path overrun flag records a sample period that began while the previous request was still unserved.

Top module: `codec_dma_req`

## Requirements
- R1: The playback path raises requests only when `pb_en`=1 and `pb_pio`=0. The capture path raises requests only when `cap_en`=1 and `cap_pio`=0. With its PIO bit set, a path ignores its phase marker.
- R2: A one-cycle `ph_play` pulse on an enabled playback path makes the playback request high from the next cycle. A one-cycle `ph_cap` pulse does the same for capture.
- R3: A pending request stays high until its sample is fully transferred. A strobe falling edge counts only when the path's acknowledge is low (active low). Strobes with the acknowledge high change nothing.
- R4: Bytes per sample come from `bsel`: 00 gives 1 byte, 01 gives 2 bytes, and 10 or 11 give 4 bytes. Playback bytes are counted on falling edges of `wr_n` and capture bytes on falling edges of `rd_n`. The byte index (`pb_byte`/`cap_byte`) advances by one per acknowledged byte. On the last byte it returns to 0 and the request drops in the next cycle.
- R5: With `single_ch`=1, capture requests appear on `pb_req` and are acknowledged through `pb_ack_n`. `cap_req` stays low and `cap_ack_n` has no effect.
- R6: With `single_ch`=1 and both `pb_en` and `cap_en` set, the block works as playback only, and `ph_cap` raises no request.
- R7: Clearing an enable bit does not withdraw a request that is already high. The request stays up until one full sample is transferred, and after that the path raises no new requests.
- R8: `cnt_load` loads the transfer counter from `cnt_base`. Each completed sample decrements it, at most once per cycle. A completion that finds the counter at 0 reloads it from `cnt_base` and sets `irq`. `irq` stays set until `flag_clr`.
- R9: A phase marker that arrives while that path's request is already pending queues no second request and sets the path's overrun flag. The flag stays set until `flag_clr`.
- R10: `pb_done`/`cap_done` pulse high for exactly one cycle, in the same cycle the request drops after the last byte of a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_play | input | 1 | Playback phase marker, early in the sample period |
| ph_cap | input | 1 | Capture phase marker, late in the sample period |
| pb_en | input | 1 | Playback enable |
| cap_en | input | 1 | Capture enable |
| pb_pio | input | 1 | Playback in programmed I/O (no DMA) |
| cap_pio | input | 1 | Capture in programmed I/O (no DMA) |
| single_ch | input | 1 | Single-channel DMA mode |
| bsel | input | 2 | Bytes-per-sample select |
| pb_ack_n | input | 1 | Playback-pair acknowledge, active low |
| cap_ack_n | input | 1 | Capture-pair acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| cnt_base | input | CNT_W | Transfer counter base value |
| cnt_load | input | 1 | Load counter from `cnt_base` |
| flag_clr | input | 1 | Clears interrupt and overrun flags |
| pb_req | output | 1 | Playback-pair DMA request |
| cap_req | output | 1 | Capture-pair DMA request |
| pb_done | output | 1 | Playback sample complete pulse |
| cap_done | output | 1 | Capture sample complete pulse |
| irq | output | 1 | Sticky counter-underflow interrupt |
| pb_ovr | output | 1 | Playback overrun flag |
| cap_ovr | output | 1 | Capture overrun flag |
| pb_byte | output | 2 | Playback byte index within sample |
| cap_byte | output | 2 | Capture byte index within sample |

## Verification
The bench targets the release point of multi-byte samples. A design that releases on the first strobe would drop the request after one byte of a 2- or 4-byte sample.

It also sends strobes with the acknowledge high, and capture strobes on the unused acknowledge in single-channel mode. A controller that counted those strobes would shift its byte index or end a sample early.

It clears an enable while a request is pending and sends a second marker before service. A design that withdrew requests would lose the final sample, and one that queued a second request would keep the line high after service.

Finally, it places the interrupt exactly on the completion that takes the counter below zero. An off-by-one decrement would raise it a sample early or late.

// File: rtl/codec_dma_req.sv
module codec_dma_req #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_play,
  input  logic             ph_cap,
  input  logic             pb_en,
  input  logic             cap_en,
  input  logic             pb_pio,
  input  logic             cap_pio,
  input  logic             single_ch,
  input  logic [1:0]       bsel,
  input  logic             pb_ack_n,
  input  logic             cap_ack_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [CNT_W-1:0] cnt_base,
  input  logic             cnt_load,
  input  logic             flag_clr,
  output logic             pb_req,
  output logic             cap_req,
  output logic             pb_done,
  output logic             cap_done,
  output logic             irq,
  output logic             pb_ovr,
  output logic             cap_ovr,
  output logic [1:0]       pb_byte,
  output logic [1:0]       cap_byte
);

  logic             rd_q, wr_q, p_pend, c_pend;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       last_idx;

  always_comb
    case (bsel)
      2'b00:   last_idx = 2'd0;
      2'b01:   last_idx = 2'd1;
      default: last_idx = 2'd3;
    endcase

  wire rd_fall = rd_q & ~rd_n;
  wire wr_fall = wr_q & ~wr_n;
  wire play_on = pb_en & ~pb_pio;
  wire cap_on  = cap_en & ~cap_pio & ~(single_ch & pb_en);
  wire set_p   = ph_play & play_on;
  wire set_c   = ph_cap & cap_on;
  wire p_stb   = p_pend & ~pb_ack_n & wr_fall;
  wire c_ack   = single_ch ? (~pb_ack_n & ~p_pend) : ~cap_ack_n;
  wire c_stb   = c_pend & c_ack & rd_fall;
  wire p_last  = p_stb & (pb_byte == last_idx);
  wire c_last  = c_stb & (cap_byte == last_idx);
  wire any_end = p_last | c_last;
  wire uflow   = any_end & ~cnt_load & (cnt == '0);

  assign pb_req  = single_ch ? (p_pend | c_pend) : p_pend;
  assign cap_req = single_ch ? 1'b0 : c_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_pend  <= 1'b0;
      c_pend  <= 1'b0;
      pb_byte <= '0;
      cap_byte <= '0;
      pb_done <= 1'b0;
      cap_done <= 1'b0;
    end else begin
      p_pend   <= (p_pend & ~p_last) | set_p;
      c_pend   <= (c_pend & ~c_last) | set_c;
      pb_done  <= p_last;
      cap_done <= c_last;
      if (p_stb) pb_byte <= p_last ? 2'd0 : pb_byte + 2'd1;
      if (c_stb) cap_byte <= c_last ? 2'd0 : cap_byte + 2'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pb_ovr  <= 1'b0;
      cap_ovr <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pb_ovr  <= (pb_ovr & ~flag_clr) | (set_p & p_pend & ~p_last);
      cap_ovr <= (cap_ovr & ~flag_clr) | (set_c & c_pend & ~c_last);
      irq     <= (irq & ~flag_clr) | uflow;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (cnt_load)   cnt <= cnt_base;
    else if (uflow)      cnt <= cnt_base;
    else if (any_end)    cnt <= cnt - 1'b1;

endmodule

// File: rtl/codec_dma_req_chk.sv
module codec_dma_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       single_ch,
  input logic       pb_req,
  input logic       cap_req,
  input logic       pb_done,
  input logic       cap_done,
  input logic       irq,
  input logic       pb_ovr,
  input logic [1:0] pb_byte,
  input logic [1:0] cap_byte
);

  // R3
  cap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_req) && !single_ch && $past(!single_ch) |-> cap_done);

  // R3
  pb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pb_req) && $stable(single_ch) |-> (pb_done || cap_done));

  // R5
  single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single_ch && $past(single_ch) |-> !cap_req);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pb_done || cap_done));

  // R9
  ovr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_ovr) |-> pb_req);

  // R4
  pb_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_done |-> pb_byte == 2'd0);

  // R4
  cap_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> cap_byte == 2'd0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_done |=> !pb_done);

endmodule

bind codec_dma_req codec_dma_req_chk u_chk (
  .clk(clk), .rst_n(rst_n), .single_ch(single_ch), .pb_req(pb_req),
  .cap_req(cap_req), .pb_done(pb_done), .cap_done(cap_done), .irq(irq),
  .pb_ovr(pb_ovr), .pb_byte(pb_byte), .cap_byte(cap_byte)
);

// File: tb/codec_dma_req_tb.sv
module codec_dma_req_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ph_play = 0, ph_cap = 0, pb_en = 0, cap_en = 0, pb_pio = 0, cap_pio = 0;
  logic single_ch = 0, pb_ack_n = 1, cap_ack_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] bsel = 2'b00;
  logic [15:0] cnt_base = '0;
  logic cnt_load = 0, flag_clr = 0;
  logic pb_req, cap_req, pb_done, cap_done, irq, pb_ovr, cap_ovr;
  logic [1:0] pb_byte, cap_byte;

  int nchk = 0, nerr = 0;
  bit ended = 0;
  byte exp_q[$];

  always #4 clk = ~clk;

  codec_dma_req u_dut (.*);

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic pulse_play();
    @(negedge clk) ph_play = 1;
    @(negedge clk) ph_play = 0;
  endtask

  task automatic pulse_cap();
    @(negedge clk) ph_cap = 1;
    @(negedge clk) ph_cap = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1;
    @(negedge clk) flag_clr = 0;
  endtask

  // ack: 0 none, 1 playback pair, 2 capture pair
  task automatic one_byte(input bit rd, input int ack);
    @(negedge clk);
    if (ack == 1) pb_ack_n = 0;
    if (ack == 2) cap_ack_n = 0;
    if (rd) rd_n = 0; else wr_n = 0;
    @(negedge clk);
    rd_n = 1; wr_n = 1; pb_ack_n = 1; cap_ack_n = 1;
  endtask

  task automatic sample(input byte tag, input int n, input bit rd, input int ack);
    exp_q.push_back(tag);
    for (int i = 0; i < n; i++) one_byte(rd, ack);
  endtask

  // monitor: completion pulses against the scoreboard (R10)
  always @(negedge clk) if (rst_n && !ended) begin
    if (pb_done) begin
      if (exp_q.size() == 0) chk("R10 unexpected pb_done", 1, 0);
      else chk("R10 playback completion", int'(exp_q.pop_front()), int'("P"));
    end
    if (cap_done) begin
      if (exp_q.size() == 0) chk("R10 unexpected cap_done", 1, 0);
      else chk("R10 capture completion", int'(exp_q.pop_front()), int'("C"));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nerr++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset pb_req", pb_req, 0);
    chk("R2 reset cap_req", cap_req, 0);
    chk("R8 reset irq", irq, 0);

    // R1: PIO bits block requests
    pb_en = 1; cap_en = 1; pb_pio = 1; cap_pio = 1;
    pulse_play(); chk("R1 pio playback", pb_req, 0);
    pulse_cap();  chk("R1 pio capture", cap_req, 0);
    pb_pio = 0; cap_pio = 0;

    // R2/R3/R4: 1-byte playback
    bsel = 2'b00;
    pulse_play(); chk("R2 playback request", pb_req, 1);
    chk("R2 capture quiet", cap_req, 0);
    one_byte(0, 0); chk("R3 unacked strobe", pb_req, 1);
    sample("P", 1, 0, 1); chk("R4 1-byte release", pb_req, 0);

    // R4: 2-byte capture
    bsel = 2'b01;
    pulse_cap(); chk("R2 capture request", cap_req, 1);
    one_byte(1, 2); chk("R4 capture index", cap_byte, 1);
    chk("R4 capture held", cap_req, 1);
    exp_q.push_back("C"); one_byte(1, 2);
    chk("R4 2-byte release", cap_req, 0); chk("R4 capture wrap", cap_byte, 0);

    // R4: 4-byte playback
    bsel = 2'b10;
    pulse_play();
    for (int i = 0; i < 3; i++) one_byte(0, 1);
    chk("R4 4-byte held", pb_req, 1); chk("R4 playback index", pb_byte, 3);
    sample("P", 1, 0, 1); chk("R4 4-byte release", pb_req, 0);
    bsel = 2'b00;

    // R7: disable keeps pending request
    pulse_play(); pb_en = 0;
    @(negedge clk); chk("R7 request kept", pb_req, 1);
    sample("P", 1, 0, 1); chk("R7 final served", pb_req, 0);
    pulse_play(); chk("R7 idle after disable", pb_req, 0);
    pb_en = 1;

    // R9: overrun
    pulse_play(); pulse_play();
    chk("R9 overrun set", pb_ovr, 1);
    sample("P", 1, 0, 1); chk("R9 no queued request", pb_req, 0);
    chk("R9 overrun sticky", pb_ovr, 1);
    pulse_clr(); chk("R9 overrun cleared", pb_ovr, 0);

    // R5: single-channel capture
    single_ch = 1; pb_en = 0; cap_en = 1;
    pulse_cap(); chk("R5 capture on pb_req", pb_req, 1);
    chk("R5 cap_req low", cap_req, 0);
    one_byte(1, 2); chk("R5 cap_ack ignored", pb_req, 1);
    chk("R5 index untouched", cap_byte, 0);
    sample("C", 1, 1, 1); chk("R5 served via pb pair", pb_req, 0);

    // R6: both enables -> playback
    pb_en = 1;
    pulse_cap(); chk("R6 capture ignored", pb_req, 0);
    pulse_play(); chk("R6 playback request", pb_req, 1);
    sample("P", 1, 0, 1); chk("R6 playback served", pb_req, 0);

    // R8: counter underflow
    single_ch = 0; cap_en = 0;
    pulse_clr(); chk("R8 irq cleared", irq, 0);
    cnt_base = 16'd2;
    @(negedge clk) cnt_load = 1;
    @(negedge clk) cnt_load = 0;
    for (int i = 0; i < 2; i++) begin pulse_play(); sample("P", 1, 0, 1); end
    chk("R8 no early irq", irq, 0);
    pulse_play(); sample("P", 1, 0, 1);
    chk("R8 underflow irq", irq, 1);
    @(negedge clk); chk("R8 irq sticky", irq, 1);
    pulse_clr(); chk("R8 irq clear", irq, 0);

    repeat (4) @(negedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule